// File: doc/BRIEF.md
# Disk Write Cell Serializer

This block is the write path of a single-density disk formatter. A host keeps a byte in a holding register. Each time the serializer finishes the previous byte, it copies that byte into its own working register and pulses a transfer flag, so the host knows to place the next byte. The serializer then plays the byte out on a single pulse line, one slot per half-cell tick. Each bit cell has two slots: a clock slot and then a data slot.

There are two cell formats. In normal format the byte carries eight data bits, and the block inserts a clock pulse in every cell. In raw format the byte already holds four clock/data pairs, and they are emitted exactly as given. Raw format is how address marks with missing clocks are written: one eight-cell mark takes two consecutive raw bytes.

A 16-bit CRC register accumulates the normal-format data while enabled. When the CRC enable is low, the block sends the CRC register instead of the host byte, so two transfers put the remainder on the media. While sync is low, the CRC register is held at all ones. The format and CRC enable inputs are sampled only at a byte transfer.

Top module: `rawcell_serializer`

## Requirements
- R1: After reset, and on every tick while `wr_gate` is low, `pulse_out` and `byte_xfer` stay low and no byte is transferred.
- R2: With `wr_gate` high, a transfer happens on the first tick, and again on the tick after the last slot of a byte. `byte_xfer` is high for exactly the one clock that follows that tick.
- R3: A normal-format byte uses 16 slots. Even slots (clock) always pulse. Slot 2k+1 carries byte bit 7-k, so the MSB goes first.
- R4: A raw-format byte uses 8 slots. Slot k carries byte bit 7-k, which means the layout from the MSB down is clock1, data1, clock2, data2, clock3, data3, clock4, data4. No clock pulse is inserted.
- R5: `raw_mode` and `crc_en` are sampled only at a transfer. Changing them partway through a byte changes neither the slots nor the slot count of that byte.
- R6: While `sync_en` is low, the CRC register is all ones. A normal-format transfer with `crc_en` low then sends 8'hFF.
- R7: A normal-format transfer with `crc_en` and `sync_en` high folds the byte into the CRC, MSB first, using the polynomial x^16+x^12+x^5+1.
- R8: A normal-format transfer with `crc_en` low sends the upper CRC byte and shifts the CRC left by eight with zero fill. Two such transfers therefore send the full remainder, high byte first.
- R9: Raw-format transfers never change the CRC register. They always send the host byte, whatever the value of `crc_en`.
- R10: `pulse_out` can be high only in the clock that follows a tick taken with `wr_gate` high. Each slot is exactly one clock wide.
- R11: When `wr_gate` drops in the middle of a byte, output stops. Raising it again starts a fresh transfer at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_tick | input | 1 | Half-cell slot strobe, one clock wide |
| wr_gate | input | 1 | Write active |
| raw_mode | input | 1 | 1: raw interleaved clock/data format |
| crc_en | input | 1 | 1: accumulate CRC, 0: send CRC register |
| sync_en | input | 1 | 0: hold CRC register at all ones |
| data_byte | input | 8 | Host holding register |
| pulse_out | output | 1 | Serial clock/data pulse, one slot per tick |
| byte_xfer | output | 1 | Byte moved into the working register |

## Verification
The bench targets the byte boundaries where the slot count changes between 16 and 8. If the count were wrong, a raw byte would borrow slots from its neighbour and every later transfer would land one slot off. It flips the format and the CRC enable partway through a byte: a design that sampled these live would drop clock pulses or cut the byte short. A raw byte is placed between CRC-covered bytes, so a design that folded raw bytes into the CRC would send a wrong remainder. The bench also covers a dropped write gate followed by a restart, and a CRC-source byte sent while sync is low, which must come out as all ones.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned DEF_BYTE_BITS = 8;
  localparam int unsigned DEF_CRC_BITS  = 16;
  localparam logic [15:0] DEF_CRC_POLY  = 16'h1021;

  typedef enum logic {
    FMT_NORMAL = 1'b0,
    FMT_RAW    = 1'b1
  } cell_fmt_t;
endpackage

// File: rtl/rcs_crc.sv
module rcs_crc #(
  parameter int unsigned          BW   = rcs_pkg::DEF_BYTE_BITS,
  parameter int unsigned          CW   = rcs_pkg::DEF_CRC_BITS,
  parameter logic [CW-1:0]        POLY = rcs_pkg::DEF_CRC_POLY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_en,
  input  logic          load,
  input  rcs_pkg::cell_fmt_t fmt,
  input  logic          crc_en,
  input  logic [BW-1:0] data_in,
  output logic [BW-1:0] crc_hi
);
  logic [CW-1:0] crc_q;

  function automatic logic [CW-1:0] fold(input logic [CW-1:0] c, input logic [BW-1:0] b);
    logic [CW-1:0] r;
    logic          fb;
    r = c;
    for (int i = BW - 1; i >= 0; i--) begin
      fb = r[CW-1] ^ b[i];
      r  = {r[CW-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !sync_en) begin
      crc_q <= '1;
    end else if (load && fmt == rcs_pkg::FMT_NORMAL) begin
      if (crc_en) crc_q <= fold(crc_q, data_in);
      else        crc_q <= crc_q << BW;
    end
  end

  assign crc_hi = crc_q[CW-1 -: BW];

  // R6
  preset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> crc_q == '1);
  // R9
  raw_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (load && fmt == rcs_pkg::FMT_RAW && sync_en) |=> $stable(crc_q));
  // R8
  zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (load && fmt == rcs_pkg::FMT_NORMAL && !crc_en && sync_en) |=> crc_q[BW-1:0] == '0);
endmodule

// File: rtl/rcs_sequencer.sv
module rcs_sequencer #(
  parameter int unsigned BW = rcs_pkg::DEF_BYTE_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cell_tick,
  input  logic               wr_gate,
  input  rcs_pkg::cell_fmt_t fmt_in,
  input  logic [BW-1:0]      src_byte,
  output logic               load,
  output logic               pulse_out,
  output logic               byte_xfer
);
  localparam int unsigned SLOTS_N = 2 * BW;
  localparam int unsigned SW      = $clog2(SLOTS_N);

  logic [SW-1:0]      slot_q;
  logic [SW-1:0]      last_slot;
  logic               busy_q;
  rcs_pkg::cell_fmt_t fmt_q;
  logic [BW-1:0]      byte_q;
  logic               advance;

  function automatic logic slot_val(input logic [BW-1:0] b, input rcs_pkg::cell_fmt_t f,
                                    input logic [SW-1:0] s);
    int idx;
    if (f == rcs_pkg::FMT_RAW) begin
      idx = int'(BW) - 1 - int'(s);
      return b[idx];
    end
    if (!s[0]) return 1'b1;
    idx = int'(BW) - 1 - int'(s >> 1);
    return b[idx];
  endfunction

  assign last_slot = (fmt_q == rcs_pkg::FMT_RAW) ? SW'(BW - 1) : SW'(SLOTS_N - 1);
  assign load      = cell_tick && wr_gate && (!busy_q || slot_q == last_slot);
  assign advance   = cell_tick && wr_gate && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      slot_q    <= '0;
      fmt_q     <= rcs_pkg::FMT_NORMAL;
      byte_q    <= '0;
      pulse_out <= 1'b0;
      byte_xfer <= 1'b0;
    end else begin
      byte_xfer <= load;
      pulse_out <= 1'b0;
      if (!wr_gate) busy_q <= 1'b0;
      if (load) begin
        busy_q    <= 1'b1;
        slot_q    <= '0;
        fmt_q     <= fmt_in;
        byte_q    <= src_byte;
        pulse_out <= slot_val(src_byte, fmt_in, '0);
      end else if (advance) begin
        slot_q    <= slot_q + 1'b1;
        pulse_out <= slot_val(byte_q, fmt_q, slot_q + 1'b1);
      end
    end
  end

  // R10
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> $past(cell_tick && wr_gate));
  // R2
  xfer_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    byte_xfer |-> $past(cell_tick && wr_gate));
  // R3
  clock_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && fmt_q == rcs_pkg::FMT_NORMAL && slot_q[0]) |=> pulse_out);
  // R11
  gate_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_gate |=> (!pulse_out && !byte_xfer));
endmodule

// File: rtl/rawcell_serializer.sv
module rawcell_serializer #(
  parameter int unsigned   BYTE_BITS = rcs_pkg::DEF_BYTE_BITS,
  parameter int unsigned   CRC_BITS  = rcs_pkg::DEF_CRC_BITS,
  parameter logic [15:0]   CRC_POLY  = rcs_pkg::DEF_CRC_POLY
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cell_tick,
  input  logic                 wr_gate,
  input  logic                 raw_mode,
  input  logic                 crc_en,
  input  logic                 sync_en,
  input  logic [BYTE_BITS-1:0] data_byte,
  output logic                 pulse_out,
  output logic                 byte_xfer
);
  rcs_pkg::cell_fmt_t   fmt;
  logic [BYTE_BITS-1:0] crc_hi;
  logic [BYTE_BITS-1:0] src_byte;
  logic                 load;

  assign fmt      = raw_mode ? rcs_pkg::FMT_RAW : rcs_pkg::FMT_NORMAL;
  assign src_byte = (fmt == rcs_pkg::FMT_NORMAL && !crc_en) ? crc_hi : data_byte;

  rcs_crc #(
    .BW   (BYTE_BITS),
    .CW   (CRC_BITS),
    .POLY (CRC_POLY[CRC_BITS-1:0])
  ) u_crc (
    .clk     (clk),
    .rst     (rst),
    .sync_en (sync_en),
    .load    (load),
    .fmt     (fmt),
    .crc_en  (crc_en),
    .data_in (data_byte),
    .crc_hi  (crc_hi)
  );

  rcs_sequencer #(
    .BW (BYTE_BITS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cell_tick (cell_tick),
    .wr_gate   (wr_gate),
    .fmt_in    (fmt),
    .src_byte  (src_byte),
    .load      (load),
    .pulse_out (pulse_out),
    .byte_xfer (byte_xfer)
  );
endmodule

// File: tb/rawcell_serializer_test.sv
module rawcell_serializer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cell_tick = 1'b0;
  logic       wr_gate = 1'b0;
  logic       raw_mode = 1'b0;
  logic       crc_en = 1'b1;
  logic       sync_en = 1'b0;
  logic [7:0] data_byte = 8'h00;
  logic       pulse_out;
  logic       byte_xfer;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic mon_on = 1'b0;
  logic tick_seen = 1'b0;
  logic [15:0] crc_m = 16'hFFFF;

  bit    exp_p[$];
  bit    exp_x[$];
  string exp_t[$];

  always #10 clk = ~clk;

  rawcell_serializer uut (
    .clk(clk), .rst(rst), .cell_tick(cell_tick), .wr_gate(wr_gate),
    .raw_mode(raw_mode), .crc_en(crc_en), .sync_en(sync_en),
    .data_byte(data_byte), .pulse_out(pulse_out), .byte_xfer(byte_xfer)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    tick_seen <= cell_tick && wr_gate;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // monitor: pop expected slots as ticks are taken
  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (tick_seen) begin
        if (exp_p.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected slot: pulse_out=%0b expected no slot", pulse_out);
        end else begin
          bit p, x; string t;
          p = exp_p.pop_front(); x = exp_x.pop_front(); t = exp_t.pop_front();
          if (pulse_out !== p || byte_xfer !== x) begin
            errors++;
            $display("FAIL %s pulse_out=%0b byte_xfer=%0b expected %0b %0b", t, pulse_out, byte_xfer, p, x);
          end
        end
      end else if (pulse_out !== 1'b0 || byte_xfer !== 1'b0) begin
        errors++;
        $display("FAIL R10 idle cycle pulse_out=%0b byte_xfer=%0b expected 0 0", pulse_out, byte_xfer);
      end
    end
  end

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic tick_once();
    @(posedge clk); #5 cell_tick = 1'b1;
    @(posedge clk); #5 cell_tick = 1'b0;
    @(posedge clk);
  endtask

  // cut: number of slots to play (0 = whole byte); flip: toggle modes after 3 slots
  task automatic send_byte(input logic [7:0] b, input bit raw, input bit ce, input bit sy,
                           input string tag, input int cut, input bit flip);
    logic [7:0] sent;
    int n;
    @(posedge clk); #5;
    data_byte = b; raw_mode = raw; crc_en = ce; sync_en = sy;
    if (!sy) crc_m = 16'hFFFF;
    sent = (!raw && !ce) ? crc_m[15:8] : b;
    if (sy && !raw) crc_m = ce ? crc_step(crc_m, b) : {crc_m[7:0], 8'h00};
    n = raw ? 8 : 16;
    if (cut != 0) n = cut;
    for (int s = 0; s < n; s++) begin
      bit v;
      if (raw)           v = sent[7 - s];
      else if (s % 2 == 0) v = 1'b1;
      else               v = sent[7 - s / 2];
      exp_p.push_back(v);
      exp_x.push_back(s == 0);
      exp_t.push_back((s == 0) ? {tag, " R2"} : tag);
    end
    for (int s = 0; s < n; s++) begin
      tick_once();
      if (flip && s == 2) begin
        #5 raw_mode = !raw; crc_en = !ce;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (pulse_out !== 1'b0 || byte_xfer !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset pulse_out=%0b byte_xfer=%0b expected 0 0", pulse_out, byte_xfer);
    end
    mon_on = 1'b1;
    // R1: ticks with gate low give nothing
    repeat (3) tick_once();
    @(posedge clk); #5 wr_gate = 1'b1;
    // R3: normal format, sync low
    send_byte(8'hA5, 0, 1, 0, "R3", 0, 0);
    send_byte(8'h00, 0, 1, 0, "R3", 0, 0);
    send_byte(8'hFF, 0, 1, 0, "R3", 0, 0);
    // R4: raw address-mark pair
    send_byte(8'hF5, 1, 1, 0, "R4", 0, 0);
    send_byte(8'h7E, 1, 0, 0, "R4 R9", 0, 0);
    // R7: accumulate with sync high, raw byte in between (R9)
    send_byte(8'hA1, 0, 1, 1, "R7", 0, 0);
    send_byte(8'hAA, 1, 1, 1, "R4 R9", 0, 0);
    send_byte(8'h5E, 0, 1, 1, "R7", 0, 0);
    send_byte(8'h12, 0, 1, 1, "R7", 0, 0);
    // R8: remainder out, high then low byte
    send_byte(8'h00, 0, 0, 1, "R7 R8 R9", 0, 0);
    send_byte(8'h00, 0, 0, 1, "R7 R8 R9", 0, 0);
    // R5: mode flips mid-byte have no effect
    send_byte(8'h3C, 0, 1, 1, "R5", 0, 1);
    send_byte(8'hC3, 1, 1, 1, "R5", 0, 1);
    // R6: sync low gives all-ones CRC source byte
    send_byte(8'h55, 0, 0, 0, "R6", 0, 0);
    // R11: gate drop mid-byte, then restart fresh
    send_byte(8'h96, 0, 1, 1, "R11", 5, 0);
    @(posedge clk); #5 wr_gate = 1'b0;
    repeat (2) tick_once();
    @(posedge clk); #5 wr_gate = 1'b1;
    send_byte(8'h69, 0, 1, 1, "R11", 0, 0);
    repeat (4) @(posedge clk);
    checks++;
    if (exp_p.size() != 0) begin
      errors++;
      $display("FAIL R2 slots left=%0d expected 0", exp_p.size());
    end
    summary();
  end
endmodule